// File: doc/BRIEF.md
# Two-Cache Write-Invalidate Snooping Bus

This block gives two cores private, direct-mapped, write-through caches. The two caches share a single bus to one memory, which lies outside the block. Each core holds a request until the block raises that core's ready. A read that hits completes at once. A read that misses, and every write, must first win the bus. An alternating arbiter grants one cache per cycle.

Every write on the bus goes through to memory. It also acts as an invalidate that the other cache snoops. If the other cache holds that address, it drops its copy, so its next read misses and fetches the value just written. A miss fetches data in its bus cycle and installs it one cycle later. If the other cache writes that same address between the fetch and the install, the install is abandoned and the read goes back to the bus. Memory reads are combinational on `mem_rdata_i`. Memory writes take effect at the clock edge that closes the bus write cycle.

Top module: `coh_snoop_pair`

## Requirements
- R1: After reset every line in both caches is invalid, no core sees ready, no bus cycle is active, and the first read of any address misses.
- R2: A read that hits raises that core's ready in the same cycle as the request, with the line's data and no bus cycle (`mem_req_o` low).
- R3: A read that misses, once granted, drives one bus read cycle. Ready rises in the following cycle with the memory value, so an uncontended miss completes in its second cycle.
- R4: Every write is write-through. The core's ready rises only in the cycle its cache holds the grant, and in that cycle `mem_we_o` is high with the core's address and data.
- R5: A write by one cache invalidates a matching valid line in the other cache. That cache's next read of the address misses and returns the written value.
- R6: A write that hits updates the writer's own line. A write that misses allocates nothing, so the next read of that address by the same core misses.
- R7: At most one bit of `bus_gnt_o` is set. When both caches request in the same cycle, the cache that was not granted most recently wins, and the other keeps ready low. After reset, cache 0 has priority.
- R8: A snooped write to the address a cache is about to install cancels that install. The read returns to the bus and completes with the newly written value.
- R9: Lines are indexed by the low log2(LINES) address bits (bits 2:0 by default). Two addresses with the same index evict each other.
- R10: A read miss seen on the bus does not change the other cache's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_req_i | input | 2 | Per-core request, held until ready |
| core_we_i | input | 2 | Per-core write select (1 = write) |
| core_addr_i | input | 2 x AW | Per-core word address |
| core_wdata_i | input | 2 x DW | Per-core write data |
| core_rdy_o | output | 2 | Per-core completion |
| core_rdata_o | output | 2 x DW | Per-core read data, valid with ready on a read |
| bus_gnt_o | output | 2 | Bus grant, one-hot or zero |
| mem_req_o | output | 1 | Bus cycle active |
| mem_we_o | output | 1 | Bus cycle is a write |
| mem_addr_o | output | AW | Bus address |
| mem_wdata_o | output | DW | Bus write data |
| mem_rdata_i | input | DW | Memory read data for `mem_addr_o`, combinational |

## Verification
The bench repeats a read, read, write, read pattern on one location with fresh data each time. A stale second copy would show up as a hit carrying old data, and a working invalidate shows up as a miss carrying the new word. A read repeated by the same core and a write to an uncached address separate the hit path from the no-allocate path. A pair of reads to addresses with the same index shows eviction, and a read miss on the other side shows that bus reads leave the snooping cache alone. Simultaneous requests show alternating priority. A read miss collided with a write to the same address, timed so the write lands between fetch and install, shows the cancelled install and the reissue.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int unsigned NCORE = 2;
  typedef enum logic {CS_IDLE, CS_FILL} cache_st_e;
endpackage

// File: rtl/coh_arb.sv
module coh_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  output logic [1:0] gnt_o
);
  logic last_q; // index of cache granted most recently

  always_comb begin
    gnt_o[0] = req_i[0] & (~req_i[1] | last_q);
    gnt_o[1] = req_i[1] & (~req_i[0] | ~last_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= 1'b1;
    else if (|gnt_o)   last_q <= gnt_o[1];
  end
endmodule

// File: rtl/coh_cache.sv
module coh_cache
  import coh_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned LINES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rdy_o,
  output logic [DW-1:0] rdata_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_gnt_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          snp_vld_i,
  input  logic [AW-1:0] snp_addr_i
);
  localparam int unsigned IW = $clog2(LINES);
  localparam int unsigned TW = AW - IW;

  cache_st_e        st_q;
  logic [LINES-1:0] vld_q;
  logic [TW-1:0]    tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES];
  logic [AW-1:0]    fill_addr_q;
  logic [DW-1:0]    fill_data_q;

  logic [IW-1:0] idx, snp_idx, fill_idx;
  logic [TW-1:0] tag, snp_tag, fill_tag;
  logic          hit, snp_hit, fill_kill;

  assign idx      = addr_i[IW-1:0];
  assign tag      = addr_i[AW-1:IW];
  assign snp_idx  = snp_addr_i[IW-1:0];
  assign snp_tag  = snp_addr_i[AW-1:IW];
  assign fill_idx = fill_addr_q[IW-1:0];
  assign fill_tag = fill_addr_q[AW-1:IW];

  assign hit       = vld_q[idx] && (tag_q[idx] == tag);
  assign snp_hit   = snp_vld_i && vld_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  assign fill_kill = snp_vld_i && (snp_addr_i == fill_addr_q);

  assign bus_req_o   = (st_q == CS_IDLE) && req_i && (we_i || !hit);
  assign bus_we_o    = we_i;
  assign bus_addr_o  = addr_i;
  assign bus_wdata_o = wdata_i;

  always_comb begin
    if (st_q == CS_FILL) begin
      rdy_o   = !fill_kill;
      rdata_o = fill_data_q;
    end else begin
      rdy_o   = req_i && (we_i ? bus_gnt_i : hit);
      rdata_o = dat_q[idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= CS_IDLE;
      fill_addr_q <= '0;
      fill_data_q <= '0;
    end else if (st_q == CS_IDLE) begin
      if (bus_gnt_i && !we_i) begin
        st_q        <= CS_FILL;
        fill_addr_q <= addr_i;
        fill_data_q <= bus_rdata_i;
      end
    end else begin
      st_q <= CS_IDLE; // killed fill returns to IDLE and reissues
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      if (snp_hit) vld_q[snp_idx] <= 1'b0;
      if (st_q == CS_FILL && !fill_kill) vld_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (st_q == CS_FILL && !fill_kill) begin
      tag_q[fill_idx] <= fill_tag;
      dat_q[fill_idx] <= fill_data_q;
    end else if (st_q == CS_IDLE && bus_gnt_i && we_i && hit) begin
      dat_q[idx] <= wdata_i;
    end
  end
endmodule

// File: rtl/coh_snoop_pair.sv
module coh_snoop_pair
  import coh_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned LINES = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NCORE-1:0]         core_req_i,
  input  logic [NCORE-1:0]         core_we_i,
  input  logic [NCORE-1:0][AW-1:0] core_addr_i,
  input  logic [NCORE-1:0][DW-1:0] core_wdata_i,
  output logic [NCORE-1:0]         core_rdy_o,
  output logic [NCORE-1:0][DW-1:0] core_rdata_o,
  output logic [NCORE-1:0]         bus_gnt_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [AW-1:0]            mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o,
  input  logic [DW-1:0]            mem_rdata_i
);
  logic [NCORE-1:0]         bus_req, bus_we;
  logic [NCORE-1:0][AW-1:0] bus_addr;
  logic [NCORE-1:0][DW-1:0] bus_wdata;

  coh_arb u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (bus_req),
    .gnt_o (bus_gnt_o)
  );

  assign mem_req_o   = |bus_gnt_o;
  assign mem_we_o    = |(bus_gnt_o & bus_we);
  assign mem_addr_o  = bus_gnt_o[1] ? bus_addr[1]  : bus_addr[0];
  assign mem_wdata_o = bus_gnt_o[1] ? bus_wdata[1] : bus_wdata[0];

  for (genvar g = 0; g < NCORE; g++) begin : g_cache
    logic snp_vld;
    assign snp_vld = mem_we_o && bus_gnt_o[NCORE-1-g];

    coh_cache #(.AW(AW), .DW(DW), .LINES(LINES)) u_cache (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (core_req_i[g]),
      .we_i       (core_we_i[g]),
      .addr_i     (core_addr_i[g]),
      .wdata_i    (core_wdata_i[g]),
      .rdy_o      (core_rdy_o[g]),
      .rdata_o    (core_rdata_o[g]),
      .bus_req_o  (bus_req[g]),
      .bus_we_o   (bus_we[g]),
      .bus_addr_o (bus_addr[g]),
      .bus_wdata_o(bus_wdata[g]),
      .bus_gnt_i  (bus_gnt_o[g]),
      .bus_rdata_i(mem_rdata_i),
      .snp_vld_i  (snp_vld),
      .snp_addr_i (mem_addr_o)
    );
  end
endmodule

// File: rtl/coh_snoop_chk.sv
module coh_snoop_chk #(
  parameter int unsigned AW = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         core_req_i,
  input logic [1:0]         core_we_i,
  input logic [1:0][AW-1:0] core_addr_i,
  input logic [1:0]         core_rdy_o,
  input logic [1:0]         bus_gnt_o,
  input logic [1:0]         bus_req,
  input logic               mem_we_o,
  input logic [AW-1:0]      mem_addr_o
);
  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_gnt_o)); // R7

  AST_ALT_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&bus_req && $past(&bus_req && bus_gnt_o[0])) |-> bus_gnt_o[1]); // R7

  AST_WR_ACK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_i[0] && core_we_i[0] && core_rdy_o[0]) |-> (bus_gnt_o[0] && mem_we_o)); // R4

  AST_WR_ACK1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_i[1] && core_we_i[1] && core_rdy_o[1]) |-> (bus_gnt_o[1] && mem_we_o)); // R4

  AST_INV_MISS1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_i[1] && !core_we_i[1] && $past(mem_we_o && bus_gnt_o[0])
     && core_addr_i[1] == $past(mem_addr_o)) |-> !core_rdy_o[1]); // R5

  AST_INV_MISS0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_i[0] && !core_we_i[0] && $past(mem_we_o && bus_gnt_o[1])
     && core_addr_i[0] == $past(mem_addr_o)) |-> !core_rdy_o[0]); // R5
endmodule

bind coh_snoop_pair coh_snoop_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .core_req_i (core_req_i),
  .core_we_i  (core_we_i),
  .core_addr_i(core_addr_i),
  .core_rdy_o (core_rdy_o),
  .bus_gnt_o  (bus_gnt_o),
  .bus_req    (bus_req),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/tb_coh_snoop_pair.sv
module tb_coh_snoop_pair;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [1:0]            core_req = '0;
  logic [1:0]            core_we = '0;
  logic [1:0][AW-1:0]    core_addr = '0;
  logic [1:0][DW-1:0]    core_wdata = '0;
  logic [1:0]            core_rdy;
  logic [1:0][DW-1:0]    core_rdata;
  logic [1:0]            bus_gnt;
  logic                  mem_req, mem_we;
  logic [AW-1:0]         mem_addr;
  logic [DW-1:0]         mem_wdata, mem_rdata;
  logic [DW-1:0]         bmem [256];

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_snoop_pair dut (
    .clk_i(clk), .rst_ni(rst_n),
    .core_req_i(core_req), .core_we_i(core_we),
    .core_addr_i(core_addr), .core_wdata_i(core_wdata),
    .core_rdy_o(core_rdy), .core_rdata_o(core_rdata),
    .bus_gnt_o(bus_gnt), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = bmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [DW-1:0] init_val(input int a);
    return 32'hC0DE_0000 | a;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one core access; cyc = cycles with ready low before completion
  task automatic access(input int c, input bit we, input int a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int cyc,
                        output bit mreq, output bit mwe);
    @(negedge clk);
    core_req[c]   = 1'b1;
    core_we[c]    = we;
    core_addr[c]  = AW'(a);
    core_wdata[c] = wd;
    cyc = 0;
    forever begin
      #1;
      if (core_rdy[c]) break;
      @(negedge clk);
      cyc++;
    end
    rd   = core_rdata[c];
    mreq = mem_req;
    mwe  = mem_we;
    @(negedge clk);
    core_req[c] = 1'b0;
    core_we[c]  = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] rd; int cyc; bit mq, mw;
    #1;
    check(core_rdy == 2'b00, "R1 ready after reset", {30'd0, core_rdy}, 0);
    check(mem_req == 1'b0, "R1 bus idle after reset", {31'd0, mem_req}, 0);
    access(0, 0, 5, 0, rd, cyc, mq, mw);
    check(cyc == 1, "R1 R3 first read misses", cyc, 1);
    check(rd == init_val(5), "R3 miss data", rd, init_val(5));
  endtask

  task automatic t_hit();
    logic [DW-1:0] rd; int cyc; bit mq, mw;
    access(0, 0, 5, 0, rd, cyc, mq, mw);
    check(cyc == 0, "R2 hit latency", cyc, 0);
    check(!mq, "R2 no bus cycle on hit", {31'd0, mq}, 0);
    check(rd == init_val(5), "R2 hit data", rd, init_val(5));
  endtask

  task automatic t_rrwr(input logic [DW-1:0] v);
    logic [DW-1:0] rd; int cyc; bit mq, mw;
    access(0, 0, 9, 0, rd, cyc, mq, mw);
    access(1, 0, 9, 0, rd, cyc, mq, mw);
    access(0, 1, 9, v, rd, cyc, mq, mw);
    check(cyc == 0 && mw, "R4 write granted with mem_we", {31'd0, mw}, 1);
    #1;
    check(bmem[9] == v, "R4 memory written through", bmem[9], v);
    access(1, 0, 9, 0, rd, cyc, mq, mw);
    check(cyc == 1, "R5 reader misses after invalidate", cyc, 1);
    check(rd == v, "R5 reader gets new value", rd, v);
    access(0, 0, 9, 0, rd, cyc, mq, mw);
    check(cyc == 0 && rd == v, "R6 writer line updated", rd, v);
  endtask

  task automatic t_wmiss();
    logic [DW-1:0] rd; int cyc; bit mq, mw;
    access(1, 1, 30, 32'h5A5A_0030, rd, cyc, mq, mw);
    access(1, 0, 30, 0, rd, cyc, mq, mw);
    check(cyc == 1, "R6 write miss does not allocate", cyc, 1);
    check(rd == 32'h5A5A_0030, "R6 read after write miss", rd, 32'h5A5A_0030);
  endtask

  task automatic t_conflict();
    logic [DW-1:0] rd; int cyc; bit mq, mw;
    access(0, 0, 3, 0, rd, cyc, mq, mw);
    access(0, 0, 11, 0, rd, cyc, mq, mw);
    check(rd == init_val(11), "R9 second index data", rd, init_val(11));
    access(0, 0, 3, 0, rd, cyc, mq, mw);
    check(cyc == 1, "R9 same index evicts", cyc, 1);
  endtask

  task automatic t_snoop_read();
    logic [DW-1:0] rd; int cyc; bit mq, mw;
    access(1, 0, 50, 0, rd, cyc, mq, mw);
    access(0, 0, 50, 0, rd, cyc, mq, mw);
    access(1, 0, 50, 0, rd, cyc, mq, mw);
    check(cyc == 0 && rd == init_val(50), "R10 read miss leaves other cache", cyc, 0);
  endtask

  task automatic t_arb();
    logic [DW-1:0] rd0, rd1; int c0, c1; bit q0, w0, q1, w1;
    access(0, 1, 60, 32'h60, rd0, c0, q0, w0); // cache 0 granted last
    for (int k = 0; k < 2; k++) begin
      fork
        access(0, 1, 61 + 2*k, 32'h61 + 2*k, rd0, c0, q0, w0);
        access(1, 1, 62 + 2*k, 32'h62 + 2*k, rd1, c1, q1, w1);
      join
      check(c1 == 0, "R7 alternate winner first", c1, 0);
      check(c0 == 1, "R7 loser waits one cycle", c0, 1);
    end
  endtask

  task automatic t_cancel();
    logic [DW-1:0] rd0, rd1; int c0, c1; bit q0, w0, q1, w1;
    access(1, 0, 70, 0, rd1, c1, q1, w1); // cache 1 granted last
    fork
      access(0, 0, 77, 0, rd0, c0, q0, w0);
      access(1, 1, 77, 32'hFEED_0077, rd1, c1, q1, w1);
    join
    check(c1 == 1, "R8 writer granted during fill", c1, 1);
    check(rd0 == 32'hFEED_0077, "R8 cancelled fill returns new value", rd0, 32'hFEED_0077);
    check(c0 == 3, "R8 read reissued", c0, 3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit();
    for (int k = 0; k < 3; k++) t_rrwr(32'hAB00_0000 + k * 32'h111);
    t_wmiss();
    t_conflict();
    t_snoop_read();
    t_arb();
    t_cancel();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule